// File: doc/BRIEF.md
# I2C Byte-Memory Target with Event Flags

This block is an I2C target that exposes a small internal byte memory to an external I2C controller and reports bus activity to a local host through sticky event flags. It runs on the system clock. It samples SCL and SDA inputs that have already been synchronized. It never drives SDA high: it only asserts an open-drain pull-down enable. The target address is programmable and can be 7 or 10 bits wide. A write transaction starts with a memory-address phase of 0 to 4 bytes, sent MSB first. The data bytes that follow land in memory at consecutive locations. Reads return bytes from the current location and advance it in the same way.

Byte data crosses the block only on the I2C bus. The host side carries no data stream, only plain control and status pins. The target never stretches SCL, so nothing on the host side can apply back-pressure. The controller alone sets the pace, and the block reacts within two system clocks of every SCL edge. For this reason SCL must stay at each level for at least four system clocks.

The memory depth `MEM_DEPTH` is a parameter with a default of 8 bytes. It must be a power of two.

Top module: `i2c_mem_target`

## Requirements
- R1: While `enable` is low, the block acknowledges no address, never asserts `sda_oe`, and raises no event.
- R2: In 7-bit mode, a first address byte whose upper seven bits equal `target_addr[6:0]` is ACKed. Bit 0 of that byte is the direction (1 = read). A write match sets event bit 1 and a read match sets event bit 0. Any other address is NACKed and the transaction is ignored.
- R3: In 10-bit mode, a write is addressed by the header `11110,target_addr[9:8],0` followed by a byte equal to `target_addr[7:0]`. Both bytes are ACKed. The header with direction bit 1 is ACKed only after a repeated START that follows a matched 10-bit write. A mismatching second byte, or a read header with no prior 10-bit write, is NACKed.
- R4: After a write match, the next `mem_addr_bytes` bytes (0 to 4; larger values are treated as 4) form the memory address, MSB first. Each of these bytes is ACKed. The assembled value appears on `mem_addr_q`, and the memory location becomes that value modulo `MEM_DEPTH`.
- R5: Each write data byte is ACKed and stored at the current location. The location then advances by one and wraps modulo `MEM_DEPTH`. Each such byte sets event bit 3.
- R6: In a read, each byte is taken from the current location and sent MSB first, and the location advances by one. Each byte handed to the bus sets event bit 2. On a controller NACK the block releases SDA and waits for a START or STOP.
- R7: A repeated START followed by a matching read returns data from the location set by the preceding write's address phase.
- R8: A STOP or repeated START ends a matched transaction. A read sets event bit 4 and a write sets event bit 5.
- R9: When `mem_addr_bytes` is nonzero, a write transaction that carries no data byte does not set event bit 5.
- R10: Event flags are sticky. A flag clears in the cycle after a 1 on the matching bit of `evt_clear`. A new event in the same cycle wins over the clear.
- R11: `irq` is the OR of the flags that are enabled in the trigger mask. The mask resets to `6'b110000` (both end events) and is loaded from `evt_mask_wdata` when `evt_mask_we` is high.
- R12: While the block is enabled, `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Target enable |
| addr_10bit | input | 1 | 1 selects 10-bit target addressing |
| target_addr | input | 10 | Target address (low 7 bits in 7-bit mode) |
| mem_addr_bytes | input | 3 | Length in bytes of the memory-address phase |
| scl_in | input | 1 | Synchronized SCL level |
| sda_in | input | 1 | Synchronized SDA level |
| sda_oe | output | 1 | 1 pulls SDA low |
| mem_addr_q | output | 32 | Most recently selected memory address |
| evt_mask_we | input | 1 | Load strobe for the trigger mask |
| evt_mask_wdata | input | 6 | New trigger mask value |
| evt_clear | input | 6 | Write-1-to-clear for the event flags |
| evt_flags | output | 6 | Sticky event flags |
| irq | output | 1 | Interrupt, OR of masked flags |

## Verification
A wrong internal state in this block shows up on the bus within one byte. A corrupted location pointer or address assembly makes the next read return a byte that differs from the one written, on the first data bit. A bad address compare or state step shows as a missing or spurious ACK on the ninth clock of that same byte. Event misbehaviour shows in the flags a few cycles after the STOP or repeated START, for example an end-of-write flag after an address-only write, or a flag that survives no clear. Mask errors show directly on `irq` one cycle after the mask is written.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int EV_W        = 6;
  localparam int EV_MATCH_RD = 0;
  localparam int EV_MATCH_WR = 1;
  localparam int EV_RD_REQ   = 2;
  localparam int EV_WR_DATA  = 3;
  localparam int EV_END_RD   = 4;
  localparam int EV_END_WR   = 5;
  localparam logic [EV_W-1:0] EV_MASK_RST = 6'b110000;
  localparam int MAX_ADDR_BYTES = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_RX_ACKW, S_RX_ACK, S_TX, S_TX_ACK, S_TX_LOAD, S_WAIT
  } eng_state_t;

  typedef enum logic [1:0] {
    PH_ADDR1, PH_ADDR2, PH_MADDR, PH_DATA
  } phase_t;
endpackage

// File: rtl/i2ct_bus_cond.sv
module i2ct_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
    end
  end

  assign scl_rise  = scl_in & ~scl_q;
  assign scl_fall  = ~scl_in & scl_q;
  assign start_det = scl_in & scl_q & sda_q & ~sda_in;
  assign stop_det  = scl_in & scl_q & ~sda_q & sda_in;
endmodule

// File: rtl/i2ct_byte_mem.sv
module i2ct_byte_mem #(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/i2ct_event_regs.sv
module i2ct_event_regs
  import i2ct_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_W-1:0] evt_pulse,
  input  logic            mask_we,
  input  logic [EV_W-1:0] mask_wdata,
  input  logic [EV_W-1:0] clear,
  output logic [EV_W-1:0] flags,
  output logic            irq
);
  logic [EV_W-1:0] mask_q;

  for (genvar i = 0; i < EV_W; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= evt_pulse[i] | (flags[i] & ~clear[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= EV_MASK_RST;
    else if (mask_we) mask_q <= mask_wdata;
  end

  assign irq = |(flags & mask_q);
endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
  import i2ct_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            addr_10bit,
  input  logic [9:0]      target_addr,
  input  logic [2:0]      mem_addr_bytes,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            start_det,
  input  logic            stop_det,
  input  logic            sda_bit,
  input  logic [7:0]      mem_rdata,
  output logic            sda_oe,
  output logic [31:0]     mem_addr_q,
  output logic [EV_W-1:0] evt_pulse,
  output logic            mem_we,
  output logic [AW-1:0]   mem_waddr,
  output logic [7:0]      mem_wdata,
  output logic [AW-1:0]   ptr
);
  eng_state_t  state;
  phase_t      phase;
  logic [2:0]  bit_cnt;
  logic [7:0]  rx_sh, tx_sh;
  logic        ack_q, go_rd;
  logic        txn_act, txn_rd, data_seen, tenbit_arm;
  logic [31:0] maddr_acc;
  logic [2:0]  maddr_cnt;

  logic [7:0]  rx_byte;
  logic [2:0]  ab_eff;
  logic        hdr10_ok, a7_ok;
  logic [31:0] maddr_next;

  assign rx_byte    = {rx_sh[6:0], sda_bit};
  assign ab_eff     = (mem_addr_bytes > 3'(MAX_ADDR_BYTES)) ? 3'(MAX_ADDR_BYTES) : mem_addr_bytes;
  assign hdr10_ok   = (rx_byte[7:3] == 5'b11110) && (rx_byte[2:1] == target_addr[9:8]);
  assign a7_ok      = (rx_byte[7:1] == target_addr[6:0]);
  assign maddr_next = {maddr_acc[23:0], rx_byte};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      phase      <= PH_ADDR1;
      bit_cnt    <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      ack_q      <= 1'b0;
      go_rd      <= 1'b0;
      txn_act    <= 1'b0;
      txn_rd     <= 1'b0;
      data_seen  <= 1'b0;
      tenbit_arm <= 1'b0;
      maddr_acc  <= '0;
      maddr_cnt  <= '0;
      mem_addr_q <= '0;
      ptr        <= '0;
      sda_oe     <= 1'b0;
      evt_pulse  <= '0;
      mem_we     <= 1'b0;
      mem_waddr  <= '0;
      mem_wdata  <= '0;
    end else begin
      evt_pulse <= '0;
      mem_we    <= 1'b0;
      if (!enable) begin
        state      <= S_IDLE;
        sda_oe     <= 1'b0;
        txn_act    <= 1'b0;
        tenbit_arm <= 1'b0;
      end else if (start_det || stop_det) begin
        if (txn_act) begin
          if (txn_rd)                          evt_pulse[EV_END_RD] <= 1'b1;
          else if (ab_eff == 3'd0 || data_seen) evt_pulse[EV_END_WR] <= 1'b1;
        end
        txn_act <= 1'b0;
        sda_oe  <= 1'b0;
        bit_cnt <= '0;
        phase   <= PH_ADDR1;
        state   <= start_det ? S_RX : S_IDLE;
        if (stop_det) tenbit_arm <= 1'b0;
      end else begin
        case (state)
          S_RX: if (scl_rise) begin
            rx_sh <= rx_byte;
            if (bit_cnt != 3'd7) begin
              bit_cnt <= bit_cnt + 3'd1;
            end else begin
              state <= S_RX_ACKW;
              go_rd <= 1'b0;
              ack_q <= 1'b1;
              case (phase)
                PH_ADDR1: begin
                  if (!addr_10bit) begin
                    if (a7_ok) begin
                      go_rd   <= rx_byte[0];
                      txn_act <= 1'b1;
                      txn_rd  <= rx_byte[0];
                      if (rx_byte[0]) evt_pulse[EV_MATCH_RD] <= 1'b1;
                      else begin
                        evt_pulse[EV_MATCH_WR] <= 1'b1;
                        phase     <= (ab_eff != 3'd0) ? PH_MADDR : PH_DATA;
                        maddr_acc <= '0;
                        maddr_cnt <= '0;
                        data_seen <= 1'b0;
                      end
                    end else begin
                      ack_q <= 1'b0;
                    end
                  end else begin
                    if (hdr10_ok && !rx_byte[0]) begin
                      phase <= PH_ADDR2;
                    end else if (hdr10_ok && rx_byte[0] && tenbit_arm) begin
                      go_rd   <= 1'b1;
                      txn_act <= 1'b1;
                      txn_rd  <= 1'b1;
                      evt_pulse[EV_MATCH_RD] <= 1'b1;
                    end else begin
                      ack_q <= 1'b0;
                    end
                  end
                end
                PH_ADDR2: begin
                  if (rx_byte == target_addr[7:0]) begin
                    txn_act    <= 1'b1;
                    txn_rd     <= 1'b0;
                    tenbit_arm <= 1'b1;
                    evt_pulse[EV_MATCH_WR] <= 1'b1;
                    phase     <= (ab_eff != 3'd0) ? PH_MADDR : PH_DATA;
                    maddr_acc <= '0;
                    maddr_cnt <= '0;
                    data_seen <= 1'b0;
                  end else begin
                    ack_q      <= 1'b0;
                    tenbit_arm <= 1'b0;
                  end
                end
                PH_MADDR: begin
                  maddr_acc <= maddr_next;
                  maddr_cnt <= maddr_cnt + 3'd1;
                  if ((maddr_cnt + 3'd1) == ab_eff) begin
                    mem_addr_q <= maddr_next;
                    ptr        <= maddr_next[AW-1:0];
                    phase      <= PH_DATA;
                  end
                end
                default: begin
                  mem_we    <= 1'b1;
                  mem_waddr <= ptr;
                  mem_wdata <= rx_byte;
                  ptr       <= ptr + AW'(1);
                  data_seen <= 1'b1;
                  evt_pulse[EV_WR_DATA] <= 1'b1;
                end
              endcase
            end
          end
          S_RX_ACKW: if (scl_fall) begin
            if (ack_q) begin
              sda_oe <= 1'b1;
              state  <= S_RX_ACK;
            end else begin
              state <= S_WAIT;
            end
          end
          S_RX_ACK: if (scl_fall) begin
            if (go_rd) begin
              tx_sh   <= mem_rdata;
              sda_oe  <= ~mem_rdata[7];
              ptr     <= ptr + AW'(1);
              bit_cnt <= '0;
              state   <= S_TX;
              evt_pulse[EV_RD_REQ] <= 1'b1;
            end else begin
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
              state   <= S_RX;
            end
          end
          S_TX: if (scl_fall) begin
            if (bit_cnt == 3'd7) begin
              sda_oe <= 1'b0;
              state  <= S_TX_ACK;
            end else begin
              bit_cnt <= bit_cnt + 3'd1;
              tx_sh   <= {tx_sh[6:0], 1'b0};
              sda_oe  <= ~tx_sh[6];
            end
          end
          S_TX_ACK: if (scl_rise) begin
            state <= sda_bit ? S_WAIT : S_TX_LOAD;
          end
          S_TX_LOAD: if (scl_fall) begin
            tx_sh   <= mem_rdata;
            sda_oe  <= ~mem_rdata[7];
            ptr     <= ptr + AW'(1);
            bit_cnt <= '0;
            state   <= S_TX;
            evt_pulse[EV_RD_REQ] <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
  import i2ct_pkg::*;
#(
  parameter int MEM_DEPTH = 8,
  localparam int AW = $clog2(MEM_DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        addr_10bit,
  input  logic [9:0]  target_addr,
  input  logic [2:0]  mem_addr_bytes,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        sda_oe,
  output logic [31:0] mem_addr_q,
  input  logic        evt_mask_we,
  input  logic [5:0]  evt_mask_wdata,
  input  logic [5:0]  evt_clear,
  output logic [5:0]  evt_flags,
  output logic        irq
);
  logic            scl_rise, scl_fall, start_det, stop_det;
  logic [EV_W-1:0] evt_pulse;
  logic            mem_we;
  logic [AW-1:0]   mem_waddr, ptr;
  logic [7:0]      mem_wdata, mem_rdata;

  i2ct_bus_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2ct_engine #(.DEPTH(MEM_DEPTH)) u_eng (
    .clk(clk), .rst_n(rst_n), .enable(enable), .addr_10bit(addr_10bit),
    .target_addr(target_addr), .mem_addr_bytes(mem_addr_bytes),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_bit(sda_in),
    .mem_rdata(mem_rdata), .sda_oe(sda_oe), .mem_addr_q(mem_addr_q),
    .evt_pulse(evt_pulse), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .ptr(ptr)
  );

  i2ct_byte_mem #(.DEPTH(MEM_DEPTH)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(ptr), .rdata(mem_rdata)
  );

  i2ct_event_regs u_evt (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse),
    .mask_we(evt_mask_we), .mask_wdata(evt_mask_wdata),
    .clear(evt_clear), .flags(evt_flags), .irq(irq)
  );
endmodule

// File: rtl/i2ct_checker.sv
module i2ct_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       scl_in,
  input logic       sda_oe,
  input logic [5:0] evt_flags,
  input logic [5:0] evt_clear,
  input logic [5:0] evt_pulse,
  input logic       irq
);
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !$past(enable)) |-> !sda_oe);  // R1

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && !$stable(sda_oe)) |-> !$past(scl_in));  // R12

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(evt_flags) & ~$past(evt_clear)) & ~evt_flags) == 6'd0));  // R10

  AST_FLAG_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_flags & ~$past(evt_flags) & ~$past(evt_pulse)) == 6'd0));  // R10

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (evt_flags != 6'd0));  // R11
endmodule

bind i2c_mem_target i2ct_checker u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .scl_in(scl_in),
  .sda_oe(sda_oe), .evt_flags(evt_flags), .evt_clear(evt_clear),
  .evt_pulse(evt_pulse), .irq(irq)
);

// File: tb/tb_i2c_mem_target.sv
module tb_i2c_mem_target;
  localparam int Q = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, enable, addr_10bit, scl, sda_ctl, mask_we;
  logic [9:0]  target_addr;
  logic [2:0]  mem_addr_bytes;
  logic [5:0]  mask_wdata, clear;
  logic        sda_oe, irq, sda_line;
  logic [31:0] mem_addr_q;
  logic [5:0]  flags;

  assign sda_line = sda_ctl & ~sda_oe;

  i2c_mem_target dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .addr_10bit(addr_10bit),
    .target_addr(target_addr), .mem_addr_bytes(mem_addr_bytes),
    .scl_in(scl), .sda_in(sda_line), .sda_oe(sda_oe), .mem_addr_q(mem_addr_q),
    .evt_mask_we(mask_we), .evt_mask_wdata(mask_wdata), .evt_clear(clear),
    .evt_flags(flags), .irq(irq)
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] exp_q[$];
  logic [7:0] mon_byte;
  event rd_ev;
  logic a;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: pops the expected read byte for each byte received
  initial forever begin
    @(rd_ev);
    n_tests++;
    if (exp_q.size() == 0) begin
      n_fail++;
      $display("FAIL R6 R7 read data: actual %0h expected none", mon_byte);
    end else begin
      logic [7:0] e;
      e = exp_q.pop_front();
      if (mon_byte !== e) begin
        n_fail++;
        $display("FAIL R6 R7 read data: actual %0h expected %0h", mon_byte, e);
      end
    end
  end

  task automatic wq; repeat (Q) @(negedge clk); endtask

  task automatic i2c_start;
    sda_ctl = 1'b1; wq; scl = 1'b1; wq; sda_ctl = 1'b0; wq; scl = 1'b0; wq;
  endtask

  task automatic i2c_stop;
    sda_ctl = 1'b0; wq; scl = 1'b1; wq; sda_ctl = 1'b1; wq; wq;
  endtask

  task automatic put_bit(input logic b);
    sda_ctl = b; wq; scl = 1'b1; wq; wq; scl = 1'b0; wq;
  endtask

  task automatic get_bit(output logic b);
    sda_ctl = 1'b1; wq; scl = 1'b1; wq; b = sda_line; wq; scl = 1'b0; wq;
  endtask

  task automatic send(input logic [7:0] d, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(x);
    ack = ~x;
  endtask

  task automatic recv(input logic last);
    logic [7:0] d;
    logic x;
    for (int i = 7; i >= 0; i--) begin get_bit(x); d[i] = x; end
    put_bit(last);
    mon_byte = d;
    -> rd_ev;
  endtask

  task automatic clr_flags;
    clear = 6'h3F; @(negedge clk); clear = 6'h00; @(negedge clk);
  endtask

  task automatic set_mask(input logic [5:0] m);
    mask_wdata = m; mask_we = 1'b1; @(negedge clk); mask_we = 1'b0; @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1..: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; addr_10bit = 1'b0; target_addr = 10'h043;
    mem_addr_bytes = 3'd1; scl = 1'b1; sda_ctl = 1'b1; mask_we = 1'b0;
    mask_wdata = 6'h00; clear = 6'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset irq", {31'd0, irq}, 32'd0);
    chk("R10 reset flags", {26'd0, flags}, 32'd0);
    chk("R4 reset mem_addr_q", mem_addr_q, 32'd0);

    // R1: disabled target ignores its own address
    i2c_start(); send(8'h86, a); i2c_stop();
    chk("R1 no ack when disabled", {31'd0, a}, 32'd0);
    chk("R1 no events when disabled", {26'd0, flags}, 32'd0);
    enable = 1'b1; wq;

    // R2 R4 R5 R8: address 6, three bytes wrapping past the end
    i2c_start(); send(8'h86, a); chk("R2 addr ack", {31'd0, a}, 32'd1);
    send(8'h06, a); chk("R4 maddr ack", {31'd0, a}, 32'd1);
    send(8'hA1, a); send(8'hA2, a); send(8'hA3, a);
    chk("R5 data ack", {31'd0, a}, 32'd1);
    i2c_stop();
    chk("R4 mem_addr_q", mem_addr_q, 32'd6);
    chk("R5 R8 write flags", {26'd0, flags}, 32'h2A);
    chk("R11 irq on end event", {31'd0, irq}, 32'd1);
    clr_flags();
    chk("R10 cleared flags", {26'd0, flags}, 32'd0);
    chk("R11 irq after clear", {31'd0, irq}, 32'd0);

    // R9: address-only write raises no end-of-write
    i2c_start(); send(8'h86, a); send(8'h07, a); i2c_stop();
    chk("R9 no end_wr", {26'd0, flags}, 32'h02);
    chk("R11 unmasked event no irq", {31'd0, irq}, 32'd0);
    chk("R4 mem_addr_q update", mem_addr_q, 32'd7);
    clr_flags();

    // R7 R6: set address 6, repeated start, read three (wraps 6,7,0)
    exp_q.push_back(8'hA1); exp_q.push_back(8'hA2); exp_q.push_back(8'hA3);
    i2c_start(); send(8'h86, a); send(8'h06, a);
    i2c_start(); send(8'h87, a); chk("R2 read addr ack", {31'd0, a}, 32'd1);
    recv(1'b0); recv(1'b0); recv(1'b1);
    chk("R6 sda released after nack", {31'd0, sda_oe}, 32'd0);
    i2c_stop();
    chk("R6 R8 R9 read flags", {26'd0, flags}, 32'h17);
    clr_flags();

    // R2: wrong address NACKed and ignored
    i2c_start(); send(8'h88, a); i2c_stop();
    chk("R2 wrong addr nack", {31'd0, a}, 32'd0);
    chk("R2 wrong addr no events", {26'd0, flags}, 32'd0);

    // R11: mask selects which flags drive irq
    set_mask(6'h01);
    i2c_start(); send(8'h86, a); send(8'h00, a); send(8'h11, a); i2c_stop();
    chk("R11 masked out irq", {31'd0, irq}, 32'd0);
    set_mask(6'h02);
    chk("R11 mask includes flag", {31'd0, irq}, 32'd1);
    set_mask(6'h30);
    clr_flags();

    // R3: 10-bit addressing, two-byte memory address
    addr_10bit = 1'b1; target_addr = 10'h2A5; mem_addr_bytes = 3'd2;
    i2c_start(); send(8'hF4, a); chk("R3 header ack", {31'd0, a}, 32'd1);
    send(8'hA5, a); chk("R3 second byte ack", {31'd0, a}, 32'd1);
    send(8'h12, a); send(8'h34, a); send(8'h5C, a); i2c_stop();
    chk("R4 two-byte address", mem_addr_q, 32'h1234);
    chk("R3 R8 10-bit write flags", {26'd0, flags}, 32'h2A);
    clr_flags();
    exp_q.push_back(8'h5C);
    i2c_start(); send(8'hF4, a); send(8'hA5, a); send(8'h12, a); send(8'h34, a);
    i2c_start(); send(8'hF5, a); chk("R3 read header ack", {31'd0, a}, 32'd1);
    recv(1'b1); i2c_stop();
    chk("R3 R7 R9 10-bit read flags", {26'd0, flags}, 32'h17);
    clr_flags();
    i2c_start(); send(8'hF4, a); send(8'hA6, a); i2c_stop();
    chk("R3 wrong second byte nack", {31'd0, a}, 32'd0);
    i2c_start(); send(8'hF5, a); i2c_stop();
    chk("R3 read header without write nack", {31'd0, a}, 32'd0);
    chk("R3 no events on mismatch", {26'd0, flags}, 32'd0);

    // R4: four-byte address, low bits select location 7
    addr_10bit = 1'b0; target_addr = 10'h043; mem_addr_bytes = 3'd4;
    exp_q.push_back(8'hA2);
    i2c_start(); send(8'h86, a); send(8'hDE, a); send(8'hAD, a); send(8'hBE, a);
    send(8'hEF, a);
    i2c_start(); send(8'h87, a); recv(1'b1); i2c_stop();
    chk("R4 four-byte address", mem_addr_q, 32'hDEADBEEF);
    clr_flags();

    // R5 R9: no address phase, eight bytes wrap fully, end_wr raised
    mem_addr_bytes = 3'd0;
    i2c_start(); send(8'h86, a);
    for (int i = 0; i < 8; i++) send(8'h70 + 8'(i), a);
    i2c_stop();
    chk("R9 end_wr without address phase", {26'd0, flags}, 32'h2A);
    exp_q.push_back(8'h70);
    i2c_start(); send(8'h87, a); recv(1'b1); i2c_stop();
    wq;
    chk("R6 scoreboard drained", exp_q.size(), 32'd0);

    finish_run();
  end
endmodule